// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block sits behind a serial memory front end. It gathers the data bytes of one write transaction into a small page buffer. After a stop it copies them into the storage array, then reports the array as busy for a fixed write-cycle time. The first byte of a transaction takes its page and starting position from `base_addr`. Each later byte moves to the next position in the same page, and after the last position it wraps back to the first, so a long transaction overwrites its own earlier bytes.

Nothing reaches the array until a stop arrives. The array is then written only at the positions that were loaded, one position per clock, in ascending index order. `busy` stays high for `CYCLE_CLKS` clocks counted from the stop, and `done` pulses as `busy` falls. An abort pulse drops the gathered bytes without starting a cycle. While the block is busy, it ignores all of its transaction inputs.

Top module: `page_commit_buffer`

## Requirements
- R1: After reset, `busy`, `done` and `arr_we` are low.
- R2: The first accepted byte of a transaction takes the page from `base_addr[ADDR_W-1:IDX_W]` and the position from `base_addr[IDX_W-1:0]`. Each later byte uses the next position modulo 8 (PAGE = 2^IDX_W), inside the same page.
- R3: When a position is loaded more than once, only the last byte loaded there is written, and that position is written exactly once.
- R4: Only loaded positions are written to the array, and every other address of the page keeps its contents. The writes happen in ascending position order on `arr_addr = {page, position}`, during the first PAGE cycles of `busy`.
- R5: No array write and no `busy` happens before a stop, even after a full page of bytes. A stop with no loaded bytes is ignored.
- R6: `busy` rises in the clock after the stop is sampled and stays high for exactly `CYCLE_CLKS` cycles (`CYCLE_CLKS` > PAGE).
- R7: `done` is a single-cycle pulse in the first cycle in which `busy` is low again.
- R8: An abort while idle discards every loaded byte. A following stop then starts no cycle, and the next byte takes a fresh `base_addr`.
- R9: While `busy` is high, byte, stop and abort inputs have no effect.
- R10: `arr_we` is only ever high while `busy` is high.
- R11: Priority when inputs arrive in the same idle cycle: abort first, then a stop with loaded bytes, then a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_addr | input | ADDR_W | Page and start position, sampled on the first byte |
| byte_vld | input | 1 | A data byte is present this cycle |
| byte_data | input | DATA_W | Data byte |
| stop_pulse | input | 1 | Stop condition received |
| abort_pulse | input | 1 | Discard the transaction |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | ADDR_W | Array write address |
| arr_data | output | DATA_W | Array write data |
| busy | output | 1 | Write cycle in progress |
| done | output | 1 | Write cycle finished, one-cycle pulse |

## Verification
The hardest case to reach is a transaction that wraps: some positions are overwritten and others are left untouched, so the array must receive the latest bytes at only the loaded positions. The bench sweeps every start position against byte counts from 1 to 10 and reuses pages, so untouched positions hold earlier data that must survive. A second hard case is stimulus that arrives while the array is busy. The bench injects bytes, stops and aborts in the middle of the write cycle, then shows that the cycle length is unchanged and that the next transaction writes only its own bytes.

// File: rtl/page_commit_buffer.sv
module page_commit_buffer #(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int IDX_W      = 3,
  parameter int CYCLE_CLKS = 625000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              byte_vld,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              stop_pulse,
  input  logic              abort_pulse,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_data,
  output logic              busy,
  output logic              done
);
  localparam int PAGE  = 1 << IDX_W;
  localparam int CNT_W = $clog2(CYCLE_CLKS);
  localparam int PG_W  = ADDR_W - IDX_W;

  logic [DATA_W-1:0] pbuf_q [PAGE];
  logic [PAGE-1:0]   mask_q;
  logic [IDX_W-1:0]  idx_q;
  logic [PG_W-1:0]   page_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              busy_q, done_q;

  wire empty    = (mask_q == '0);
  wire start_wc = !busy_q && !abort_pulse && stop_pulse && !empty;
  wire wr_en    = !busy_q && !abort_pulse && !start_wc && byte_vld;
  wire [IDX_W-1:0] wr_idx = empty ? base_addr[IDX_W-1:0] : idx_q;
  wire last_cyc = busy_q && (cnt_q == CNT_W'(CYCLE_CLKS - 1));
  wire [IDX_W-1:0] scan = cnt_q[IDX_W-1:0];
  wire committing = busy_q && (cnt_q < CNT_W'(PAGE));

  assign arr_we   = committing && mask_q[scan];
  assign arr_addr = {page_q, scan};
  assign arr_data = pbuf_q[scan];
  assign busy     = busy_q;
  assign done     = done_q;

  always_ff @(posedge clk) begin
    if (wr_en) pbuf_q[wr_idx] <= byte_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      idx_q  <= '0;
      page_q <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (last_cyc) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          mask_q <= '0;
        end
      end else if (abort_pulse) begin
        mask_q <= '0;
      end else if (start_wc) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (byte_vld) begin
        mask_q[wr_idx] <= 1'b1;
        idx_q <= wr_idx + 1'b1;
        if (empty) page_q <= base_addr[ADDR_W-1:IDX_W];
      end
    end
  end

  a_r10_we_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy_q);
  a_r7_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_q);
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  a_r6_stop_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !abort_pulse && stop_pulse && mask_q != '0) |=> busy_q);
  a_r5_no_busy_without_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !stop_pulse) |=> !busy_q);
  a_r8_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && abort_pulse) |=> (mask_q == '0 && !busy_q));
  a_r9_mask_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last_cyc) |=> ($stable(mask_q) && $stable(page_q) && busy_q));
endmodule

// File: tb/page_commit_buffer_bench.sv
module page_commit_buffer_bench;
  localparam int CYC = 20;
  logic clk = 0, rst_n = 0;
  logic [7:0] base_addr = 0, byte_data = 0;
  logic byte_vld = 0, stop_pulse = 0, abort_pulse = 0;
  logic arr_we, busy, done;
  logic [7:0] arr_addr, arr_data;

  page_commit_buffer #(.CYCLE_CLKS(CYC)) u_page_commit_buffer (
    .clk(clk), .rst_n(rst_n), .base_addr(base_addr), .byte_vld(byte_vld),
    .byte_data(byte_data), .stop_pulse(stop_pulse), .abort_pulse(abort_pulse),
    .arr_we(arr_we), .arr_addr(arr_addr), .arr_data(arr_data),
    .busy(busy), .done(done));

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] mem [256];
  logic [7:0] em  [256];
  int wcount = 0, bcycles = 0, dcount = 0, ord_err = 0, dbusy_err = 0;
  int last_a = -1;

  always @(negedge clk) begin
    if (arr_we) begin
      if (int'(arr_addr) <= last_a) ord_err++;
      last_a = int'(arr_addr);
      mem[arr_addr] = arr_data;
      wcount++;
    end
    if (busy) bcycles++;
    if (done) begin
      dcount++;
      if (busy) dbusy_err++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr();
    wcount = 0; bcycles = 0; dcount = 0; ord_err = 0; dbusy_err = 0; last_a = -1;
  endtask

  task automatic put(input logic [7:0] b, input logic [7:0] d);
    @(negedge clk); byte_vld = 1; base_addr = b; byte_data = d;
    @(negedge clk); byte_vld = 0;
  endtask

  task automatic do_stop();
    @(negedge clk); stop_pulse = 1;
    @(negedge clk); stop_pulse = 0;
  endtask

  function automatic logic [7:0] dv(input int t, input int k);
    return 8'((t * 29 + k * 11 + 3) & 255);
  endfunction

  task automatic txn(input int t, input int pg, input int st, input int n);
    logic [7:0] b;
    int mis = 0;
    bit [7:0] ld = 0;
    clr();
    for (int k = 0; k < n; k++) begin
      int pos = (st + k) % 8;
      b = 8'((pg << 3) | st);
      put(b, dv(t, k));
      em[(pg << 3) | pos] = dv(t, k);
      ld[pos] = 1;
    end
    repeat (2) @(negedge clk);
    if (n == 8 && st == 0)
      chk(!busy && wcount == 0, "R5 no commit before stop", wcount, 0);
    do_stop();
    if (t % 9 == 0) chk(busy === 1'b1, "R6 busy after stop", busy, 1);
    repeat (CYC + 4) @(negedge clk);
    for (int p = 0; p < 8; p++)
      if (mem[(pg << 3) | p] !== em[(pg << 3) | p]) mis++;
    chk(mis == 0, "R2 R3 R4 page contents", mis, 0);
    chk(wcount == $countones(ld), "R3 R4 write count", wcount, $countones(ld));
    chk(ord_err == 0, "R4 ascending order", ord_err, 0);
    chk(bcycles == CYC, "R6 busy length", bcycles, CYC);
    chk(dcount == 1 && dbusy_err == 0, "R7 done pulse", dcount, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = 0; em[i] = 0; end
    repeat (3) @(negedge clk);
    chk(!busy && !done && !arr_we, "R1 reset state", {busy, done, arr_we}, 0);
    rst_n = 1;
    @(negedge clk);

    for (int st = 0; st < 8; st++)
      for (int n = 1; n <= 10; n++)
        txn(st * 10 + n, (st * 10 + n) % 32, st, n);

    clr();
    do_stop();
    repeat (4) @(negedge clk);
    chk(bcycles == 0 && wcount == 0, "R5 empty stop ignored", bcycles, 0);

    clr();
    put(8'h30, 8'hA1); put(8'h30, 8'hA2); put(8'h30, 8'hA3);
    @(negedge clk); abort_pulse = 1; @(negedge clk); abort_pulse = 0;
    do_stop();
    repeat (CYC + 2) @(negedge clk);
    chk(bcycles == 0 && wcount == 0, "R8 abort discards", wcount, 0);
    txn(200, 7, 2, 1);

    clr();
    put(8'h28, 8'h5A); put(8'h28, 8'h5B);
    em[8'h28] = 8'h5A; em[8'h29] = 8'h5B;
    do_stop();
    repeat (3) @(negedge clk);
    byte_vld = 1; base_addr = 8'h2E; byte_data = 8'hEE;
    @(negedge clk); byte_vld = 0; stop_pulse = 1;
    @(negedge clk); stop_pulse = 0; abort_pulse = 1;
    @(negedge clk); abort_pulse = 0;
    repeat (CYC) @(negedge clk);
    chk(wcount == 2 && mem[8'h28] == 8'h5A && mem[8'h29] == 8'h5B && mem[8'h2E] == em[8'h2E],
        "R9 inputs ignored while busy", wcount, 2);
    chk(bcycles == CYC && dcount == 1, "R9 cycle length unchanged", bcycles, CYC);
    txn(201, 5, 6, 1);

    clr();
    @(negedge clk); byte_vld = 1; base_addr = 8'h40; byte_data = 8'h77; stop_pulse = 1; abort_pulse = 1;
    @(negedge clk); byte_vld = 0; stop_pulse = 0; abort_pulse = 0;
    repeat (3) @(negedge clk);
    chk(!busy && wcount == 0, "R11 abort wins", busy, 0);
    put(8'h40, 8'h71);
    em[8'h40] = 8'h71;
    clr();
    @(negedge clk); byte_vld = 1; base_addr = 8'h41; byte_data = 8'h99; stop_pulse = 1;
    @(negedge clk); byte_vld = 0; stop_pulse = 0;
    repeat (CYC + 4) @(negedge clk);
    chk(wcount == 1 && mem[8'h40] == 8'h71 && mem[8'h41] == em[8'h41],
        "R11 stop beats byte", wcount, 1);

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule